// File: doc/BRIEF.md
# Flash Block Protection Guard

This unit sits between the bus and a flash memory. It checks every flash request (data read, instruction fetch, program, erase) against two protection bits held for each 2 KB block. A request that passes is passed on to the flash side one cycle later. A request that fails is stopped. A forbidden data read, or any request outside the implemented blocks, returns a bus-fault pulse. A forbidden program or erase is silently dropped and sets a raw access-violation flag, and that flag can drive the interrupt line.

Each block has a read-enable bit and a program-enable bit, and both come up as 1 from the factory. Instruction fetch is always allowed inside the implemented range, so a block with both bits at 0 can only be executed. Software may clear protection bits but can never set them again. A cleared bit lasts only until the next power-on reset, unless a commit writes the working bits into a nonvolatile shadow. The shadow is reloaded at every reset. A completion input from the program/erase engine sets a second raw flag. Raw flags can be read back, and so can their masked copies. Writing a 1 to a flag's position in the clear register clears that flag.

Top module: `flash_guard`

## Requirements
- R1: After the first reset, both protection vectors read all ones, and the mask and raw flags read zero. `irq`, `fwd_valid` and `bus_fault` are low.
- R2: An instruction fetch (`acc_kind`=1) to an implemented block is forwarded on the next cycle, whatever that block's bits are. It never faults. `fwd_addr` and `fwd_kind` repeat the request.
- R3: A data read (`acc_kind`=0) is forwarded only when the block's read-enable bit (`reg_sel`=0, bit i is block i) is 1. Otherwise `bus_fault` pulses on the next cycle and nothing is forwarded.
- R4: A program (`acc_kind`=2) or erase (`acc_kind`=3) is forwarded only when the block's program-enable bit (`reg_sel`=1) is 1. Otherwise it is dropped without a fault, and raw flag bit 0 (access violation) is set.
- R5: A request whose block index `acc_addr[ADDR_W-1:11]` is NUM_BLOCKS or more is never forwarded. It pulses `bus_fault` and sets no raw flag.
- R6: A `pe_done` pulse sets raw flag bit 1 (operation complete) on the next cycle.
- R7: `irq` is high while any raw flag that has its mask bit set (`reg_sel`=2) is 1. Reading `reg_sel`=3 returns raw AND mask, and reading `reg_sel`=5 returns the raw flags.
- R8: Writing `reg_sel`=3 clears each raw flag whose data bit is 1. If a flag is set in the same cycle that it is cleared, the set wins.
- R9: Writes to `reg_sel`=0 or 1 can only clear bits (new = old AND data). A 1 written over a 0 changes nothing.
- R10: Reset reloads both protection vectors from the nonvolatile shadow. A write to `reg_sel`=4 copies the working vectors into the shadow, so committed clears survive later resets and uncommitted clears do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| acc_valid | input | 1 | Access request valid |
| acc_kind | input | 2 | 0 read, 1 fetch, 2 program, 3 erase |
| acc_addr | input | ADDR_W | Byte address of the request |
| fwd_valid | output | 1 | Forwarded request to flash side |
| fwd_kind | output | 2 | Kind of forwarded request |
| fwd_addr | output | ADDR_W | Address of forwarded request |
| bus_fault | output | 1 | Error response pulse |
| pe_done | input | 1 | Program/erase engine finished |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | NUM_BLOCKS | Register write data |
| reg_rdata | output | NUM_BLOCKS | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The checks set up four blocks that cover the four read-enable/program-enable combinations. Each of them then gets fetches, reads, programs and erases, which separates the bit that governs each kind of request from the bit that does not. Requests to a block index past the last implemented block show that the range fault is separate from the read fault and raises no interrupt flag. Mask, clear-collision and set-back writes check the flag and write rules. Two resets, one before a commit and one after, tell the working bits apart from the shadow.

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int NUM_BLOCKS = 8,
  parameter int ADDR_W     = 16,
  parameter int BLK_SHIFT  = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic [1:0]            acc_kind,
  input  logic [ADDR_W-1:0]     acc_addr,
  output logic                  fwd_valid,
  output logic [1:0]            fwd_kind,
  output logic [ADDR_W-1:0]     fwd_addr,
  output logic                  bus_fault,
  input  logic                  pe_done,
  input  logic                  reg_wr,
  input  logic [2:0]            reg_sel,
  input  logic [NUM_BLOCKS-1:0] reg_wdata,
  output logic [NUM_BLOCKS-1:0] reg_rdata,
  output logic                  irq
);
  localparam int SEL_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

  logic [NUM_BLOCKS-1:0] rd_nv = '1;
  logic [NUM_BLOCKS-1:0] pg_nv = '1;
  logic [NUM_BLOCKS-1:0] rd_en, pg_en;
  logic [1:0]            mask, raw, clr;
  logic [SEL_W-1:0]      sidx;
  logic                  in_range, rd_bit, pg_bit, allow, fault_now, viol_now;

  assign sidx     = acc_addr[BLK_SHIFT+SEL_W-1:BLK_SHIFT];
  assign in_range = 32'(acc_addr[ADDR_W-1:BLK_SHIFT]) < NUM_BLOCKS;
  assign rd_bit   = in_range && rd_en[sidx];
  assign pg_bit   = in_range && pg_en[sidx];

  always_comb begin
    case (acc_kind)
      2'd0:    allow = rd_bit;
      2'd1:    allow = in_range;
      default: allow = pg_bit;
    endcase
  end

  assign fault_now = acc_valid && (!in_range || (acc_kind == 2'd0 && !rd_bit));
  assign viol_now  = acc_valid && in_range && acc_kind[1] && !pg_bit;
  assign clr       = (reg_wr && reg_sel == 3'd3) ? reg_wdata[1:0] : 2'b00;
  assign irq       = |(raw & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_en     <= rd_nv;
      pg_en     <= pg_nv;
      mask      <= '0;
      raw       <= '0;
      fwd_valid <= 1'b0;
      fwd_kind  <= '0;
      fwd_addr  <= '0;
      bus_fault <= 1'b0;
    end else begin
      fwd_valid <= acc_valid && allow;
      if (acc_valid && allow) begin
        fwd_kind <= acc_kind;
        fwd_addr <= acc_addr;
      end
      bus_fault <= fault_now;
      raw <= (raw & ~clr) | {pe_done, viol_now};
      if (reg_wr) begin
        case (reg_sel)
          3'd0: rd_en <= rd_en & reg_wdata;
          3'd1: pg_en <= pg_en & reg_wdata;
          3'd2: mask  <= reg_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && reg_wr && reg_sel == 3'd4) begin
      rd_nv <= rd_en;
      pg_nv <= pg_en;
    end
  end

  always_comb begin
    case (reg_sel)
      3'd0:    reg_rdata = rd_en;
      3'd1:    reg_rdata = pg_en;
      3'd2:    reg_rdata = NUM_BLOCKS'(mask);
      3'd3:    reg_rdata = NUM_BLOCKS'(raw & mask);
      3'd5:    reg_rdata = NUM_BLOCKS'(raw);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int NUM_BLOCKS = 8,
  parameter int ADDR_W     = 16,
  parameter int BLK_SHIFT  = 11
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_valid,
  input logic [1:0]            acc_kind,
  input logic [ADDR_W-1:0]     acc_addr,
  input logic                  fwd_valid,
  input logic                  bus_fault,
  input logic                  pe_done,
  input logic [NUM_BLOCKS-1:0] rd_en,
  input logic [NUM_BLOCKS-1:0] pg_en,
  input logic [1:0]            raw
);
  localparam int SEL_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  logic             seen;
  logic             inr;
  logic [SEL_W-1:0] bidx;

  assign inr  = 32'(acc_addr[ADDR_W-1:BLK_SHIFT]) < NUM_BLOCKS;
  assign bidx = acc_addr[BLK_SHIFT+SEL_W-1:BLK_SHIFT];

  always_ff @(posedge clk) seen <= rst_n;

  // R3
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_valid && bus_fault));

  // R2
  fetch_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == 2'd1 && inr |=> fwd_valid && !bus_fault);

  // R4
  pe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind[1] && inr && !pg_en[bidx] |=> !fwd_valid && !bus_fault && raw[0]);

  // R5
  range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !inr |=> bus_fault && !fwd_valid);

  // R6
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_done |=> raw[1]);

  // R9
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (((rd_en & ~$past(rd_en)) == '0) && ((pg_en & ~$past(pg_en)) == '0)));
endmodule

bind flash_guard flash_guard_chk #(
  .NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)
) u_chk (.*);

// File: tb/test_flash_guard.sv
`timescale 1ns/1ps
module test_flash_guard;
  localparam int NB = 8;
  localparam int AW = 16;

  logic          clk = 0, rst_n = 0;
  logic          acc_valid = 0, pe_done = 0, reg_wr = 0;
  logic [1:0]    acc_kind = 0;
  logic [AW-1:0] acc_addr = 0;
  logic [2:0]    reg_sel = 0;
  logic [NB-1:0] reg_wdata = 0;
  logic          fwd_valid, bus_fault, irq;
  logic [1:0]    fwd_kind;
  logic [AW-1:0] fwd_addr;
  logic [NB-1:0] reg_rdata;
  int nchk = 0, nfail = 0;

  flash_guard #(.NUM_BLOCKS(NB), .ADDR_W(AW)) i_flash_guard (.*);

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [NB-1:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [NB-1:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic rd_chk(input logic [2:0] s, input logic [NB-1:0] exp, input string req);
    logic [NB-1:0] v;
    rd(s, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic acc(input logic [1:0] k, input logic [AW-1:0] a, input bit efwd, input bit eflt, input string req);
    @(negedge clk); acc_valid = 1; acc_kind = k; acc_addr = a;
    @(negedge clk); acc_valid = 0;
    check(fwd_valid == efwd && bus_fault == eflt, req, {fwd_valid, bus_fault}, {efwd, eflt});
    if (efwd) check(fwd_addr == a && fwd_kind == k, req, fwd_addr, a);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] blk(input int b);
    return AW'(b << 11);
  endfunction

  task automatic t_reset;
    rd_chk(0, '1, "R1 rd_en");
    rd_chk(1, '1, "R1 pg_en");
    rd_chk(2, 0, "R1 mask");
    rd_chk(5, 0, "R1 raw");
    check(!irq && !fwd_valid && !bus_fault, "R1 outputs", {irq, fwd_valid, bus_fault}, 0);
  endtask

  task automatic t_setup;
    wr(0, ~NB'(8'h03));
    wr(1, ~NB'(8'h05));
  endtask

  task automatic t_fetch;
    for (int b = 0; b < 4; b++) acc(1, blk(b) + 16'h24, 1, 0, "R2 fetch");
  endtask

  task automatic t_read;
    acc(0, blk(0) + 16'h10, 0, 1, "R3 read exec-only");
    acc(0, blk(1), 0, 1, "R3 read no-read");
    acc(0, blk(2) + 16'h7fc, 1, 0, "R3 read read-only");
    acc(0, blk(3), 1, 0, "R3 read open");
  endtask

  task automatic t_prog;
    acc(2, blk(0), 0, 0, "R4 program exec-only");
    rd_chk(5, 1, "R4 raw violation");
    wr(3, 1);
    rd_chk(5, 0, "R8 clear violation");
    acc(3, blk(2), 0, 0, "R4 erase read-only");
    rd_chk(5, 1, "R4 raw after erase");
    wr(3, 1);
    acc(2, blk(1) + 16'h40, 1, 0, "R4 program no-read");
    acc(3, blk(3), 1, 0, "R4 erase open");
    rd_chk(5, 0, "R4 no flag on allowed");
  endtask

  task automatic t_range;
    acc(0, blk(NB), 0, 1, "R5 read out of range");
    acc(2, blk(NB + 3), 0, 1, "R5 program out of range");
    acc(1, blk(NB), 0, 1, "R5 fetch out of range");
    rd_chk(5, 0, "R5 no raw flag");
  endtask

  task automatic t_irq;
    @(negedge clk); pe_done = 1;
    @(negedge clk); pe_done = 0;
    rd_chk(5, 2, "R6 done flag");
    check(!irq, "R7 masked off", irq, 0);
    wr(2, 2);
    #1 check(irq, "R7 irq on", irq, 1);
    rd_chk(3, 2, "R7 masked read");
    wr(2, 1);
    #1 check(!irq, "R7 other mask", irq, 0);
    rd_chk(3, 0, "R7 masked read other");
    wr(3, 2);
    rd_chk(5, 0, "R8 clear done");
    @(negedge clk); pe_done = 1; reg_wr = 1; reg_sel = 3; reg_wdata = 2;
    @(negedge clk); pe_done = 0; reg_wr = 0;
    rd_chk(5, 2, "R8 set wins");
    wr(3, 3);
    rd_chk(5, 0, "R8 clear both");
  endtask

  task automatic t_setback;
    wr(0, '1);
    rd_chk(0, ~NB'(8'h03), "R9 read bits stay");
    wr(1, '1);
    rd_chk(1, ~NB'(8'h05), "R9 program bits stay");
  endtask

  task automatic t_commit;
    do_reset;
    rd_chk(0, '1, "R10 uncommitted read bits");
    rd_chk(1, '1, "R10 uncommitted program bits");
    acc(0, blk(0), 1, 0, "R10 read after revert");
    wr(1, ~NB'(8'h10));
    wr(4, 0);
    do_reset;
    rd_chk(1, ~NB'(8'h10), "R10 committed program bits");
    rd_chk(0, '1, "R10 read bits untouched");
    acc(2, blk(4), 0, 0, "R10 committed protect");
    rd_chk(5, 1, "R10 violation flag");
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_setup;
    t_fetch;
    t_read;
    t_prog;
    t_range;
    t_irq;
    t_setback;
    t_commit;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule